// File: doc/BRIEF.md
# Six-Pin GPIO Port with Level-Change Interrupt

This block is a six-pin general-purpose I/O port that software controls through a small register bus. Each pin has a direction bit, an output latch bit and a weak pull-up enable. A global pull-up kill bit turns off every pull-up at once, and a pull-up is never on while its pin is driving. Two configuration straps take pins away from the port. One strap turns a dedicated input-only pin into a reset pin. The other strap gives two pins to the oscillator. Four pins can also serve analog inputs. They come out of power-on reset in analog mode, and in that mode they read 0 on the digital path.

Change detection compares the synchronized pin levels with a snapshot. The snapshot is loaded only when software reads or writes the port data register. A difference on any enabled digital pin sets a sticky flag. The flag keeps setting for as long as the difference remains, so software must first touch the data register and then clear the flag. The flag drives an interrupt line and, when enabled, a wake request. A warm reset (external reset or brown-out) reinitialises the port but leaves the snapshot and the change setup intact. Any change that is still pending therefore raises the flag again straight away.

Register map (3-bit address, 6-bit data): 0 data (read: pins, write: latch), 1 latch, 2 direction (1 = input), 3 pull-up enable, 4 analog select, 5 change enable, 6 control. In the control register, bit 0 is the flag, bit 1 is the wake enable and bit 2 is the pull-up kill.

Top module: `gpio_chg_port`

## Requirements
- R1: After power-on reset, the registers read as follows: latch 0, direction 0x37 (all inputs, with bit 3 reading 0), pull-up 0, analog 0x17, change enable 0 and control 0. pad_oe_o and pad_pu_o are 0.
- R2: pad_oe_o[i] is the inverse of direction bit i, and pad_out_o is the latch. Both apply only to pins that can drive. Writes to address 0 or address 1 load the latch.
- R3: Reading address 0 returns the pin levels after a two-flop synchronizer. A change applied just before the read is not yet visible. Analog-mode pins read 0.
- R4: A difference between the snapshot and the synchronized pins sets the flag (control bit 0) within three clock edges of the pin change. This holds only for pins that are change-enabled and digital.
- R5: While a difference remains, writing 0 to control bit 0 does not clear the flag.
- R6: Any read or write of address 0 loads the snapshot from the synchronized pins. If a pin change reaches the synchronizer output in the same cycle as that access, the change is absorbed and no flag is raised.
- R7: irq_o follows the flag. wake_o is high only while the flag is set and control bit 1 is set.
- R8: pad_pu_o[i] requires pull-up bit i, pin i set as an input and control bit 2 clear.
- R9: Pin 3 is input-only and has no latch or direction bit (it reads 0 and never drives). When mclr_strap_i is 1, pin 3 reads 0 as data, cannot set the flag and has no pull-up.
- R10: When osc_strap_i is 1, pins 4 and 5 read 0 in the data, latch and direction registers. They also never drive, never pull up and never set the flag.
- R11: warm_rst_i clears the latch, direction, pull-up and control registers and the flag. It keeps the snapshot, the analog select and the change enable, so a difference that is still pending sets the flag again one cycle later.
- R12: Writing 1 to control bit 0 never sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| warm_rst_i | input | 1 | Warm reset (external or brown-out), synchronous |
| pad_in_i | input | 6 | Raw pin levels |
| mclr_strap_i | input | 1 | 1: pin 3 is the reset pin |
| osc_strap_i | input | 1 | 1: pins 4 and 5 belong to the oscillator |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 6 | Write data |
| bus_rdata_o | output | 6 | Read data, combinational from the address |
| pad_out_o | output | 6 | Pin drive levels |
| pad_oe_o | output | 6 | Pin output enables |
| pad_pu_o | output | 6 | Weak pull-up enables |
| irq_o | output | 1 | Change flag |
| wake_o | output | 1 | Wake request |

## Verification
A vector table applies eight pin patterns, each paired with a setting of the analog and change-enable masks. Some patterns change an enabled digital pin and others change only a disabled or analog pin, so the table separates real mismatches from masked ones. The same table checks the analog zeroing of the data read. Directed sequences then cover a change landing in the same cycle as a data access, a clear attempt while the mismatch persists and a warm reset with a difference still pending. Each strap is also set while pins toggle, which shows that reclaimed pins are cut from reads, drives, pull-ups and the flag.

// File: rtl/gpio_chg_pkg.sv
package gpio_chg_pkg;
  localparam int unsigned ADDR_W = 3;
  typedef enum logic [ADDR_W-1:0] {
    REG_DATA   = 3'd0,
    REG_LAT    = 3'd1,
    REG_DIR    = 3'd2,
    REG_PULL   = 3'd3,
    REG_ANA    = 3'd4,
    REG_CHG_EN = 3'd5,
    REG_CTRL   = 3'd6,
    REG_NONE   = 3'd7
  } reg_addr_e;
  localparam int unsigned CTRL_FLAG   = 0;
  localparam int unsigned CTRL_WAKE   = 1;
  localparam int unsigned CTRL_PU_OFF = 2;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end
  assign q_o = sync_q;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_chg_pkg::*;
#(
  parameter int unsigned N       = 6,
  parameter int unsigned IN_ONLY = 3,
  parameter logic [N-1:0] ANA_CAP = 6'b010111
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              warm_rst_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N-1:0]      wdata_i,
  output logic [N-1:0]      rdata_o,
  input  logic [N-1:0]      pins_sync_i,
  input  logic [N-1:0]      avail_i,
  input  logic [N-1:0]      drv_ok_i,
  input  logic              flag_i,
  output logic [N-1:0]      lat_o,
  output logic [N-1:0]      dir_o,
  output logic [N-1:0]      pull_o,
  output logic [N-1:0]      ana_o,
  output logic [N-1:0]      chg_en_o,
  output logic              wake_en_o,
  output logic              pu_off_o,
  output logic              flag_clr_o,
  output logic              port_acc_o
);
  localparam logic [N-1:0] HAS_DIR = ~(N'(1) << IN_ONLY);

  reg_addr_e    reg_sel;
  logic [N-1:0] lat_q, dir_q, pull_q, ana_q, chg_en_q;
  logic         wake_en_q, pu_off_q;

  assign reg_sel = reg_addr_e'(addr_i);

  // warm reset spares the analog select and change enables
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q     <= '0;
      dir_q     <= '1;
      pull_q    <= '0;
      ana_q     <= ANA_CAP;
      chg_en_q  <= '0;
      wake_en_q <= 1'b0;
      pu_off_q  <= 1'b0;
    end else if (warm_rst_i) begin
      lat_q     <= '0;
      dir_q     <= '1;
      pull_q    <= '0;
      wake_en_q <= 1'b0;
      pu_off_q  <= 1'b0;
    end else if (wr_i) begin
      case (reg_sel)
        REG_DATA, REG_LAT: lat_q <= wdata_i & HAS_DIR;
        REG_DIR:    dir_q    <= wdata_i | ~HAS_DIR;
        REG_PULL:   pull_q   <= wdata_i;
        REG_ANA:    ana_q    <= wdata_i & ANA_CAP;
        REG_CHG_EN: chg_en_q <= wdata_i;
        REG_CTRL: begin
          wake_en_q <= wdata_i[CTRL_WAKE];
          pu_off_q  <= wdata_i[CTRL_PU_OFF];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    case (reg_sel)
      REG_DATA:   rdata_o = pins_sync_i & avail_i & ~ana_q;
      REG_LAT:    rdata_o = lat_q & drv_ok_i;
      REG_DIR:    rdata_o = dir_q & drv_ok_i;
      REG_PULL:   rdata_o = pull_q;
      REG_ANA:    rdata_o = ana_q;
      REG_CHG_EN: rdata_o = chg_en_q;
      REG_CTRL: begin
        rdata_o[CTRL_FLAG]   = flag_i;
        rdata_o[CTRL_WAKE]   = wake_en_q;
        rdata_o[CTRL_PU_OFF] = pu_off_q;
      end
      default: ;
    endcase
  end

  assign lat_o      = lat_q;
  assign dir_o      = dir_q;
  assign pull_o     = pull_q;
  assign ana_o      = ana_q;
  assign chg_en_o   = chg_en_q;
  assign wake_en_o  = wake_en_q;
  assign pu_off_o   = pu_off_q;
  assign flag_clr_o = wr_i && reg_sel == REG_CTRL && !wdata_i[CTRL_FLAG];
  assign port_acc_o = (wr_i || rd_i) && reg_sel == REG_DATA;

  p_in_only_dir_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_sel == REG_DIR || reg_sel == REG_LAT) |-> !rdata_o[IN_ONLY]);
  p_ana_reads_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_sel == REG_DATA) |-> ((rdata_o & ana_q) == '0));
  p_warm_keeps_chg_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm_rst_i |=> $stable(chg_en_q) && $stable(ana_q));
endmodule

// File: rtl/gpio_ioc.sv
module gpio_ioc #(
  parameter int unsigned N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         warm_rst_i,
  input  logic [N-1:0] pins_sync_i,
  input  logic [N-1:0] mask_i,
  input  logic         access_i,
  input  logic         clr_i,
  output logic         flag_o
);
  logic [N-1:0] snap_q;
  logic         flag_q, mism;

  assign mism = |((pins_sync_i ^ snap_q) & mask_i);

  // snapshot only cleared by power-on reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       snap_q <= '0;
    else if (access_i) snap_q <= pins_sync_i;
  end

  // an access hides a mismatch that appears in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                flag_q <= 1'b0;
    else if (warm_rst_i)        flag_q <= 1'b0;
    else if (mism && !access_i) flag_q <= 1'b1;
    else if (clr_i)             flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  p_flag_persists_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mism && !access_i && !warm_rst_i) |=> flag_q);
  p_access_resyncs_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    access_i |=> (!mism || pins_sync_i != $past(pins_sync_i) || mask_i != $past(mask_i)));
  p_clear_works_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && clr_i && !warm_rst_i && (!mism || access_i)) |=> !flag_q);
  p_warm_keeps_snap_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_rst_i && !access_i) |=> $stable(snap_q));
endmodule

// File: rtl/gpio_chg_port.sv
module gpio_chg_port
  import gpio_chg_pkg::*;
#(
  parameter int unsigned N       = 6,
  parameter int unsigned IN_ONLY = 3,
  parameter int unsigned OSC_A   = 4,
  parameter int unsigned OSC_B   = 5,
  parameter logic [N-1:0] ANA_CAP = 6'b010111
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              warm_rst_i,
  input  logic [N-1:0]      pad_in_i,
  input  logic              mclr_strap_i,
  input  logic              osc_strap_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [N-1:0]      bus_wdata_i,
  output logic [N-1:0]      bus_rdata_o,
  output logic [N-1:0]      pad_out_o,
  output logic [N-1:0]      pad_oe_o,
  output logic [N-1:0]      pad_pu_o,
  output logic              irq_o,
  output logic              wake_o
);
  localparam logic [N-1:0] IN_ONLY_M = N'(1) << IN_ONLY;
  localparam logic [N-1:0] OSC_M     = (N'(1) << OSC_A) | (N'(1) << OSC_B);

  logic [N-1:0] pins_sync, claim, avail, drv_ok;
  logic [N-1:0] lat, dir, pull, ana, chg_en;
  logic         wake_en, pu_off, flag_clr, port_acc, flag;

  assign claim  = osc_strap_i ? OSC_M : '0;
  assign avail  = ~claim & ~(mclr_strap_i ? IN_ONLY_M : '0);
  assign drv_ok = ~claim & ~IN_ONLY_M;

  gpio_sync #(.W(N)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_in_i),
    .q_o    (pins_sync)
  );

  gpio_regs #(.N(N), .IN_ONLY(IN_ONLY), .ANA_CAP(ANA_CAP)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .warm_rst_i  (warm_rst_i),
    .wr_i        (bus_wr_i),
    .rd_i        (bus_rd_i),
    .addr_i      (bus_addr_i),
    .wdata_i     (bus_wdata_i),
    .rdata_o     (bus_rdata_o),
    .pins_sync_i (pins_sync),
    .avail_i     (avail),
    .drv_ok_i    (drv_ok),
    .flag_i      (flag),
    .lat_o       (lat),
    .dir_o       (dir),
    .pull_o      (pull),
    .ana_o       (ana),
    .chg_en_o    (chg_en),
    .wake_en_o   (wake_en),
    .pu_off_o    (pu_off),
    .flag_clr_o  (flag_clr),
    .port_acc_o  (port_acc)
  );

  gpio_ioc #(.N(N)) u_ioc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .warm_rst_i  (warm_rst_i),
    .pins_sync_i (pins_sync),
    .mask_i      (chg_en & ~ana & avail),
    .access_i    (port_acc),
    .clr_i       (flag_clr),
    .flag_o      (flag)
  );

  for (genvar i = 0; i < N; i++) begin : g_pad
    assign pad_oe_o[i]  = drv_ok[i] & ~dir[i];
    assign pad_out_o[i] = drv_ok[i] & lat[i];
    assign pad_pu_o[i]  = avail[i] & pull[i] & ~pu_off & (dir[i] | ~drv_ok[i]);
  end

  assign irq_o  = flag;
  assign wake_o = flag & wake_en;

  p_pu_not_on_output_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o & pad_pu_o) == '0);
  p_wake_needs_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> !wake_o);
  p_osc_pins_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    osc_strap_i |-> ((pad_oe_o | pad_pu_o) & OSC_M) == '0);
  p_in_only_no_drive_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pad_oe_o[IN_ONLY]);
endmodule

// File: tb/gpio_chg_port_bench.sv
module gpio_chg_port_bench;
  localparam int CLK_NS = 10;

  logic       clk = 1'b0, rst_n = 1'b0, warm = 1'b0;
  logic [5:0] pins = '0;
  logic       mclr = 1'b0, osc = 1'b0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [2:0] addr = '0;
  logic [5:0] wdata = '0;
  logic [5:0] rdata, pout, poe, ppu;
  logic       irq, wake;
  int         n_tests = 0, n_fail = 0;
  logic [5:0] rv;

  always #(CLK_NS/2) clk = ~clk;

  gpio_chg_port u_gpio_chg_port (
    .clk_i(clk), .rst_ni(rst_n), .warm_rst_i(warm), .pad_in_i(pins),
    .mclr_strap_i(mclr), .osc_strap_i(osc), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .pad_out_o(pout), .pad_oe_o(poe), .pad_pu_o(ppu), .irq_o(irq), .wake_o(wake)
  );

  // {pins, analog, change_en, expected data, expected flag}
  localparam logic [24:0] VEC [8] = '{
    {6'h3F, 6'h00, 6'h3F, 6'h3F, 1'b1},
    {6'h3F, 6'h00, 6'h3F, 6'h3F, 1'b0},
    {6'h3E, 6'h00, 6'h01, 6'h3E, 1'b1},
    {6'h3C, 6'h00, 6'h01, 6'h3C, 1'b0},
    {6'h38, 6'h04, 6'h3F, 6'h38, 1'b0},
    {6'h39, 6'h04, 6'h3F, 6'h39, 1'b1},
    {6'h1D, 6'h17, 6'h3F, 6'h08, 1'b1},
    {6'h15, 6'h17, 6'h08, 6'h00, 1'b1}
  };

  task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [5:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a);
    rd = 1'b1; addr = a;
    #1 rv = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_NS * 100000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    rd_reg(1); chk("R1 latch", rv, 6'h00);
    rd_reg(2); chk("R1 dir", rv, 6'h37);
    rd_reg(3); chk("R1 pull", rv, 6'h00);
    rd_reg(4); chk("R1 analog", rv, 6'h17);
    rd_reg(5); chk("R1 chg_en", rv, 6'h00);
    rd_reg(6); chk("R1 ctrl", rv, 6'h00);
    chk("R1 oe", poe, 6'h00);
    chk("R1 pu", ppu, 6'h00);
    rd_reg(0);

    // R4 / R3 vector walk
    for (int k = 0; k < 8; k++) begin
      wr_reg(4, VEC[k][18:13]);
      wr_reg(5, VEC[k][12:7]);
      pins = VEC[k][24:19];
      idle(4);
      rd_reg(6); chk($sformatf("R4 vec%0d flag", k), {5'b0, rv[0]}, {5'b0, VEC[k][0]});
      rd_reg(0); chk($sformatf("R3 vec%0d data", k), rv, VEC[k][6:1]);
      wr_reg(6, 6'h00);
      rd_reg(6); chk($sformatf("R4 vec%0d cleared", k), {5'b0, rv[0]}, 6'h00);
    end

    wr_reg(4, 6'h00);
    wr_reg(5, 6'h3F);
    rd_reg(0);

    // R6 change landing in the access cycle is absorbed
    pins = 6'h14;
    idle(2);
    rd_reg(0); chk("R6 data on access", rv, 6'h14);
    idle(3);
    rd_reg(6); chk("R6 absorbed change", {5'b0, rv[0]}, 6'h00);

    // R7 / R5 / R12
    wr_reg(6, 6'h02);
    pins = 6'h15;
    idle(4);
    chk("R7 irq", {5'b0, irq}, 6'h01);
    chk("R7 wake", {5'b0, wake}, 6'h01);
    wr_reg(6, 6'h02);
    rd_reg(6); chk("R5 flag persists", {5'b0, rv[0]}, 6'h01);
    rd_reg(0);
    wr_reg(6, 6'h02);
    rd_reg(6); chk("R5 cleared after access", {5'b0, rv[0]}, 6'h00);
    chk("R7 wake low", {5'b0, wake}, 6'h00);
    wr_reg(6, 6'h03);
    rd_reg(6); chk("R12 write one ignored", {5'b0, rv[0]}, 6'h00);
    wr_reg(6, 6'h00);

    // R11 warm reset keeps snapshot
    wr_reg(1, 6'h01);
    pins = 6'h14;
    idle(4);
    warm = 1'b1;
    @(negedge clk);
    warm = 1'b0;
    chk("R11 flag cleared by warm", {5'b0, irq}, 6'h00);
    @(negedge clk);
    chk("R11 flag re-set", {5'b0, irq}, 6'h01);
    rd_reg(1); chk("R11 latch cleared", rv, 6'h00);
    rd_reg(5); chk("R11 chg_en kept", rv, 6'h3F);
    rd_reg(0);
    wr_reg(6, 6'h00);

    // R3 synchronizer latency
    pins = 6'h16;
    rd_reg(0); chk("R3 not yet visible", rv, 6'h14);
    idle(3);
    rd_reg(0); chk("R3 visible after sync", rv, 6'h16);
    wr_reg(6, 6'h00);

    // R2 drive
    wr_reg(2, 6'h00);
    wr_reg(1, 6'h2A);
    rd_reg(1); chk("R2 latch readback", rv, 6'h22);
    chk("R2 pad_out", pout, 6'h22);
    chk("R2 pad_oe", poe, 6'h37);
    wr_reg(0, 6'h15);
    rd_reg(1); chk("R2 data write to latch", rv, 6'h15);
    chk("R2 pad_out data write", pout, 6'h15);

    // R8 pull-ups
    wr_reg(3, 6'h3F);
    chk("R8 outputs no pull", ppu, 6'h08);
    wr_reg(2, 6'h3F);
    chk("R8 inputs pulled", ppu, 6'h3F);
    wr_reg(2, 6'h30);
    chk("R8 mixed", ppu, 6'h38);
    wr_reg(6, 6'h04);
    chk("R8 global kill", ppu, 6'h00);
    wr_reg(6, 6'h00);

    // R9 reset-pin strap
    mclr = 1'b1;
    pins = 6'h1E;
    idle(4);
    rd_reg(6); chk("R9 pin3 no flag", {5'b0, rv[0]}, 6'h00);
    rd_reg(0); chk("R9 pin3 reads 0", rv, 6'h16);
    chk("R9 pin3 no pull", ppu, 6'h30);
    mclr = 1'b0;
    idle(1);

    // R10 oscillator strap
    osc = 1'b1;
    idle(1);
    rd_reg(0); chk("R10 data", rv, 6'h0E);
    rd_reg(2); chk("R10 dir", rv, 6'h00);
    rd_reg(1); chk("R10 latch", rv, 6'h05);
    chk("R10 oe", poe, 6'h07);
    chk("R10 pu", ppu, 6'h08);
    pins = 6'h3E;
    idle(4);
    rd_reg(6); chk("R10 no flag", {5'b0, rv[0]}, 6'h00);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule